// File: doc/BRIEF.md
# Lockable-Way Miss Allocator

This block handles one data cache miss at a time for an eight-way set-associative cache. When a miss is accepted it inspects the addressed set: its valid bits, which live in the block's own tag and data arrays, and the per-way lock vector, which the requester drives. It also looks at a global enable bit. From these it decides whether the returning line may be placed and, if so, into which way. It then asks memory for the line through a request/grant handshake. It passes the returned line straight back to the requester, and it either writes the line into the chosen way or leaves the arrays untouched.

A way that is locked is never chosen as a victim. Among the unlocked ways, an invalid one is taken first. When every unlocked way already holds a line, a round-robin pointer kept for each set names the victim. If every way of the set is locked, or the cache is disabled, the miss is still fetched as a cacheable access, but it becomes forward-only. In that case a store's modified line is handed to a write-back buffer port instead of being allocated.

A combinational read port lets the rest of the cache, and the bench, observe the contents of any entry.

Top module: `lockway_miss_alloc`

## Requirements
- R1: After reset, `busy` and `mem_req` are 0 and every entry reads back with valid 0.
- R2: A miss is accepted when `miss_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle until the cycle after the response. A `miss_valid` raised while `busy` is 1 is ignored and changes neither the arrays nor the memory request.
- R3: `mem_req` rises the cycle after acceptance. It is held with a stable `mem_addr` equal to the accepted `miss_addr` (tag in the upper bits, set index in the low `SET_W` bits) until `mem_gnt` is sampled 1, and it is 0 afterwards.
- R4: In the cycle the block is awaiting data and `mem_rvalid` is 1, `rsp_valid` is 1 and `rsp_data` equals `mem_rdata`. This holds in every mode.
- R5: A line is only ever placed in a way whose bit in `way_lock` was 0 at acceptance (bit i = way i locked). When the cache is enabled and at least one way is unlocked, the response is always allocated (`fill_valid` = 1).
- R6: If some unlocked way of the set is invalid, the lowest-numbered such way is chosen.
- R7: If every unlocked way is valid, the victim is the first unlocked way at or above the set's pointer, wrapping from way 7 to way 0. After each fill the set's pointer becomes the filled way plus one, modulo 8. Pointers reset to 0.
- R8: A fill writes valid = 1, the tag, and the line in the response cycle. The line written is `miss_wdata` for a store and `mem_rdata` for a load. It is readable from the following cycle.
- R9: When all eight lock bits are 1, the response is not allocated and the arrays are unchanged.
- R10: When `cache_en` was 0 at acceptance, the response is not allocated and the arrays are unchanged.
- R11: `wb_valid` pulses in the response cycle exactly when the miss was not allocated and was a store. It carries `wb_addr` = the miss address and `wb_data` = `miss_wdata`. It never pulses on a fill or on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_en | input | 1 | Global cache enable, sampled at acceptance |
| miss_valid | input | 1 | Miss request |
| miss_addr | input | ADDR_W | Line address {tag, set} |
| miss_store | input | 1 | Miss is a store carrying a modified line |
| miss_wdata | input | LINE_W | Modified line for a store |
| way_lock | input | WAYS | Lock bits of the addressed set, bit i = way i |
| busy | output | 1 | A miss is outstanding |
| mem_req | output | 1 | Refill request to memory |
| mem_addr | output | ADDR_W | Refill line address |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Refill data valid |
| mem_rdata | input | LINE_W | Refill line |
| rsp_valid | output | 1 | Line forwarded to requester |
| rsp_data | output | LINE_W | Forwarded line |
| fill_valid | output | 1 | Line written into the arrays this cycle |
| fill_way | output | WAY_W | Way being filled |
| wb_valid | output | 1 | Modified line sent to write-back buffer |
| wb_addr | output | ADDR_W | Write-back line address |
| wb_data | output | LINE_W | Write-back line |
| rd_set | input | SET_W | Read port set index |
| rd_way | input | WAY_W | Read port way index |
| rd_valid | output | 1 | Entry valid |
| rd_tag | output | TAG_W | Entry tag |
| rd_data | output | LINE_W | Entry line |

## Verification
Acceptance happens at a rising edge. `busy` and `mem_req` are therefore due at the first falling edge after it, and `mem_req` drops at the falling edge after the edge that samples `mem_gnt`. `rsp_valid`, `fill_valid`, `fill_way` and `wb_valid` are combinational in the response cycle. The bench checks them one time unit after raising `mem_rvalid`, before the edge that writes the arrays. The array contents and the cleared `busy` are due after that edge, so the bench compares every entry through the read port at the following falling edge against its behavioural model.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } lwa_state_e;
endpackage

// File: rtl/lwa_victim.sv
module lwa_victim #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_row,
  input  logic [WAYS-1:0]  lock_row,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic             can_alloc,
  output logic             use_free,
  output logic [WAY_W-1:0] victim
);
  // lowest-numbered way that is both invalid and unlocked
  function automatic logic [WAY_W-1:0] lowest_free(input logic [WAYS-1:0] v,
                                                   input logic [WAYS-1:0] l);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!v[i] && !l[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  // first unlocked way at or after pointer p, wrapping
  function automatic logic [WAY_W-1:0] rr_from(input logic [WAYS-1:0] l,
                                               input logic [WAY_W-1:0] p);
    logic [WAY_W-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int k = 0; k < WAYS; k++) begin
      int w;
      w = (int'(p) + k) % WAYS;
      if (!found && !l[w]) begin
        r = WAY_W'(w);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  assign can_alloc = ~&lock_row;
  assign use_free  = |(~valid_row & ~lock_row);
  assign victim    = use_free ? lowest_free(valid_row, lock_row)
                              : rr_from(lock_row, rr_ptr);
endmodule

// File: rtl/lwa_store.sv
module lwa_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 8,
  parameter int TAG_W  = 8,
  parameter int LINE_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data,
  input  logic [SET_W-1:0]  row_set,
  output logic [WAYS-1:0]   row_valid,
  output logic [WAY_W-1:0]  row_ptr,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data
);
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAY_W-1:0]  ptr_q  [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [LINE_W-1:0] data_q [SETS][WAYS];

  function automatic logic [WAY_W-1:0] next_ptr(input logic [WAY_W-1:0] w);
    return (w == WAY_W'(WAYS - 1)) ? '0 : w + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        ptr_q[s] <= '0;
      end
    end else if (we) begin
      vld_q[wr_set][wr_way] <= 1'b1;
      ptr_q[wr_set]         <= next_ptr(wr_way);
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      data_q[wr_set][wr_way] <= wr_data;
    end
  end

  assign row_valid = vld_q[row_set];
  assign row_ptr   = ptr_q[row_set];
  assign rd_valid  = vld_q[rd_set][rd_way];
  assign rd_tag    = tag_q[rd_set][rd_way];
  assign rd_data   = data_q[rd_set][rd_way];
endmodule

// File: rtl/lwa_ctrl.sv
module lwa_ctrl
  import lwa_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int ADDR_W = 10,
  parameter int LINE_W = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              miss_store,
  input  logic [LINE_W-1:0] miss_wdata,
  input  logic [WAYS-1:0]   way_lock,
  input  logic              can_alloc,
  input  logic [WAY_W-1:0]  victim,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  output logic              busy,
  output logic              accept,
  output logic              mem_req,
  output logic              resp_fire,
  output logic              fill_we,
  output logic              wb_fire,
  output logic [WAY_W-1:0]  victim_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LINE_W-1:0] wdata_q,
  output logic [WAYS-1:0]   lk_q,
  output logic              en_q,
  output logic              store_q
);
  lwa_state_e state_q, state_d;
  logic       alloc_q;

  assign busy      = (state_q != ST_IDLE);
  assign accept    = miss_valid && !busy;
  assign mem_req   = (state_q == ST_REQ);
  assign resp_fire = (state_q == ST_WAIT) && mem_rvalid;
  assign fill_we   = resp_fire && alloc_q;
  assign wb_fire   = resp_fire && !alloc_q && store_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept)     state_d = ST_REQ;
      ST_REQ:  if (mem_gnt)    state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      alloc_q  <= 1'b0;
      victim_q <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      lk_q     <= '0;
      en_q     <= 1'b0;
      store_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        alloc_q  <= cache_en && can_alloc;
        victim_q <= victim;
        addr_q   <= miss_addr;
        wdata_q  <= miss_wdata;
        lk_q     <= way_lock;
        en_q     <= cache_en;
        store_q  <= miss_store;
      end
    end
  end
endmodule

// File: rtl/lockway_miss_alloc.sv
module lockway_miss_alloc #(
  parameter int SETS   = 4,
  parameter int WAYS   = 8,
  parameter int ADDR_W = 10,
  parameter int LINE_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              miss_store,
  input  logic [LINE_W-1:0] miss_wdata,
  input  logic [WAYS-1:0]   way_lock,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [LINE_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [LINE_W-1:0] rsp_data,
  output logic              fill_valid,
  output logic [WAY_W-1:0]  fill_way,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data
);
  // named internal events
  logic              accept, resp_fire, fill_we, wb_fire;
  logic              can_alloc, use_free;
  logic [WAY_W-1:0]  victim, victim_q, row_ptr;
  logic [WAYS-1:0]   row_valid, lk_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] wdata_q, fill_line;
  logic              en_q, store_q;

  lwa_victim #(.WAYS(WAYS)) u_victim (
    .valid_row (row_valid),
    .lock_row  (way_lock),
    .rr_ptr    (row_ptr),
    .can_alloc (can_alloc),
    .use_free  (use_free),
    .victim    (victim)
  );

  lwa_ctrl #(.WAYS(WAYS), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cache_en   (cache_en),
    .miss_valid (miss_valid),
    .miss_addr  (miss_addr),
    .miss_store (miss_store),
    .miss_wdata (miss_wdata),
    .way_lock   (way_lock),
    .can_alloc  (can_alloc),
    .victim     (victim),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .busy       (busy),
    .accept     (accept),
    .mem_req    (mem_req),
    .resp_fire  (resp_fire),
    .fill_we    (fill_we),
    .wb_fire    (wb_fire),
    .victim_q   (victim_q),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .lk_q       (lk_q),
    .en_q       (en_q),
    .store_q    (store_q)
  );

  assign fill_line = store_q ? wdata_q : mem_rdata;

  lwa_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (fill_we),
    .wr_set    (addr_q[SET_W-1:0]),
    .wr_way    (victim_q),
    .wr_tag    (addr_q[ADDR_W-1:SET_W]),
    .wr_data   (fill_line),
    .row_set   (miss_addr[SET_W-1:0]),
    .row_valid (row_valid),
    .row_ptr   (row_ptr),
    .rd_set    (rd_set),
    .rd_way    (rd_way),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_data   (rd_data)
  );

  assign mem_addr   = addr_q;
  assign rsp_valid  = resp_fire;
  assign rsp_data   = mem_rdata;
  assign fill_valid = fill_we;
  assign fill_way   = victim_q;
  assign wb_valid   = wb_fire;
  assign wb_addr    = addr_q;
  assign wb_data    = wdata_q;
endmodule

// File: rtl/lwa_chk.sv
module lwa_chk #(
  parameter int WAYS   = 8,
  parameter int ADDR_W = 10,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              cache_en,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rsp_valid,
  input logic              fill_valid,
  input logic [WAY_W-1:0]  fill_way,
  input logic              wb_valid,
  input logic [WAYS-1:0]   lk_q,
  input logic              en_q,
  input logic              store_q,
  input logic [WAYS-1:0]   row_valid,
  input logic [WAYS-1:0]   way_lock,
  input logic [WAY_W-1:0]  victim
);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_idle_after_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy);
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
  assert_resp_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);
  assert_fill_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> rsp_valid && !lk_q[fill_way]);
  assert_fill_when_possible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && en_q && !(&lk_q) |-> fill_valid);
  assert_free_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cache_en && |(~row_valid & ~way_lock) |-> !row_valid[victim] && !way_lock[victim]);
  assert_locked_no_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (&lk_q) |-> !fill_valid);
  assert_disabled_no_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !en_q |-> !fill_valid);
  assert_wb_only_bypass_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> rsp_valid && store_q && !fill_valid);
endmodule

bind lockway_miss_alloc lwa_chk #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .cache_en   (cache_en),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_gnt    (mem_gnt),
  .mem_addr   (mem_addr),
  .rsp_valid  (rsp_valid),
  .fill_valid (fill_valid),
  .fill_way   (fill_way),
  .wb_valid   (wb_valid),
  .lk_q       (lk_q),
  .en_q       (en_q),
  .store_q    (store_q),
  .row_valid  (row_valid),
  .way_lock   (way_lock),
  .victim     (victim)
);

// File: tb/lockway_miss_alloc_tb.sv
`timescale 1ns/1ps
module lockway_miss_alloc_tb;
  localparam int NS = 4, NW = 8, AW = 10, LW = 32;
  localparam int SW = 2, WW = 3, TW = AW - SW;

  logic clk = 0, rst_n = 0;
  logic cache_en = 1, miss_valid = 0, miss_store = 0;
  logic [AW-1:0] miss_addr = '0;
  logic [LW-1:0] miss_wdata = '0, mem_rdata = '0;
  logic [NW-1:0] way_lock = '0;
  logic mem_gnt = 0, mem_rvalid = 0;
  logic busy, mem_req, rsp_valid, fill_valid, wb_valid, rd_valid;
  logic [AW-1:0] mem_addr, wb_addr;
  logic [LW-1:0] rsp_data, wb_data, rd_data;
  logic [WW-1:0] fill_way, rd_way = '0;
  logic [SW-1:0] rd_set = '0;
  logic [TW-1:0] rd_tag;

  lockway_miss_alloc u_dut (.*);

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit          m_v   [NS][NW];
  int          m_tag [NS][NW];
  logic [LW-1:0] m_dat [NS][NW];
  int          m_ptr [NS];

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic compare_all(input string what);
    int bad = 0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        rd_set = SW'(s); rd_way = WW'(w); #0.1;
        if (rd_valid !== m_v[s][w]) bad++;
        else if (m_v[s][w] && (int'(rd_tag) != m_tag[s][w] || rd_data !== m_dat[s][w])) bad++;
      end
    chk(bad == 0, what, bad, 0);
  endtask

  task automatic miss(input int s, input int t, input logic [NW-1:0] lk, input bit en,
                      input bit st, input logic [LW-1:0] wd, input logic [LW-1:0] rd,
                      input int gd);
    bit alloc, found;
    int vic;
    logic [AW-1:0] a;
    a = {TW'(t), SW'(s)};
    alloc = en && (lk != '1);
    found = 0; vic = 0;
    for (int w = 0; w < NW; w++)
      if (!found && !m_v[s][w] && !lk[w]) begin vic = w; found = 1; end
    for (int k = 0; k < NW; k++)
      if (!found && !lk[(m_ptr[s] + k) % NW]) begin vic = (m_ptr[s] + k) % NW; found = 1; end

    @(negedge clk);
    miss_valid = 1; miss_addr = a; way_lock = lk; cache_en = en;
    miss_store = st; miss_wdata = wd;
    @(negedge clk);
    // distractor while busy: must be ignored (R2)
    miss_addr = a ^ 10'h3F0; way_lock = '0; cache_en = 1; miss_store = 1; miss_wdata = ~wd;
    chk(busy === 1'b1, "R2 busy after accept", busy, 1);
    chk(mem_req === 1'b1 && mem_addr === a, "R3 request address", mem_addr, a);
    for (int i = 0; i < gd; i++) begin
      @(negedge clk);
      chk(mem_req === 1'b1 && mem_addr === a, "R3 request held", mem_addr, a);
    end
    mem_gnt = 1;
    @(negedge clk);
    mem_gnt = 0; miss_valid = 0;
    chk(mem_req === 1'b0, "R3 request dropped after grant", mem_req, 0);
    mem_rvalid = 1; mem_rdata = rd;
    #1;
    chk(rsp_valid === 1'b1 && rsp_data === rd, "R4 forwarded data", rsp_data, rd);
    chk(fill_valid === alloc, "R5/R9/R10 allocate decision", fill_valid, alloc);
    if (alloc) chk(int'(fill_way) == vic, "R6/R7 victim way", fill_way, vic);
    chk(wb_valid === (!alloc && st), "R11 write-back pulse", wb_valid, !alloc && st);
    if (!alloc && st)
      chk(wb_addr === a && wb_data === wd, "R11 write-back payload", wb_data, wd);
    @(negedge clk);
    mem_rvalid = 0;
    chk(busy === 1'b0, "R2 idle after response", busy, 0);
    if (alloc) begin
      m_v[s][vic] = 1; m_tag[s][vic] = t; m_dat[s][vic] = st ? wd : rd;
      m_ptr[s] = (vic + 1) % NW;
    end
    compare_all(alloc ? "R8 array after fill" : "R9/R10 array unchanged");
  endtask

  initial begin
    #80000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < NW; w++) begin m_v[s][w] = 0; m_tag[s][w] = 0; m_dat[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && mem_req === 1'b0, "R1 reset outputs", {busy, mem_req}, 0);
    compare_all("R1 all entries invalid");
    // all unlocked, set fills in way order (R6)
    for (int i = 0; i < NW; i++)
      miss(2, 16 + i, 8'h00, 1, 0, 32'h0, 32'hA000_0000 + i, i % 3);
    // full set, round-robin from pointer 0 (R7)
    miss(2, 40, 8'h00, 1, 0, 32'h0, 32'hB000_0001, 1);
    // exactly one unlocked way (R5)
    miss(2, 41, 8'hDF, 1, 0, 32'h0, 32'hB000_0002, 0);
    // two unlocked ways 2 and 6, pointer 6 then wrap to 2 (R7)
    miss(2, 42, 8'hBB, 1, 1, 32'hC0DE_0003, 32'hB000_0003, 2);
    miss(2, 43, 8'hBB, 1, 0, 32'h0, 32'hB000_0004, 0);
    // fully locked: store goes to write-back, load just forwarded (R9, R11)
    miss(2, 44, 8'hFF, 1, 1, 32'hDEAD_0005, 32'hB000_0005, 1);
    miss(2, 45, 8'hFF, 1, 0, 32'h0, 32'hB000_0006, 0);
    // invalid but locked ways skipped (R6), store line written (R8)
    miss(1, 50, 8'h03, 1, 1, 32'h5151_0007, 32'hB000_0007, 0);
    // cache disabled (R10, R11)
    miss(3, 60, 8'h00, 0, 0, 32'h0, 32'hB000_0008, 1);
    miss(3, 61, 8'h00, 0, 1, 32'hFACE_0009, 32'hB000_0009, 0);
    // enabled again, first free way in set 3
    miss(3, 62, 8'h00, 1, 0, 32'h0, 32'hB000_000A, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule